// File: doc/BRIEF.md
# I2C Multi-Message Transfer Sequencer

This block runs a list of I2C messages through a byte-level master engine that reports its progress as 8-bit status codes. No software handles the individual steps. Each message is described by a 7-bit target address, a direction flag and a byte length. The sequencer presents the index of the current message on `desc_idx`, and the surrounding logic answers with that message's descriptor. Bytes to be written come in on `wr_data`, and each one is consumed by a one-cycle `wr_take` pulse. Bytes that are read leave on `rd_data` with a one-cycle `rd_valid` strobe.

A `go` pulse starts a transfer. The sequencer first waits for the engine to report the idle status. After that it reacts only to engine events (`eng_si`). For each event it decodes the status code and issues exactly one control action on the command port. Consecutive messages are joined with repeated STARTs, and the transfer closes with a STOP. At the end `done` pulses, `done_count` holds the number of messages that completed, and `done_err` holds the error class.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: After `go`, a START (command code 1) is issued in the first cycle in which `eng_status` equals 0xF8. If the bus does not report 0xF8 within TMO cycles of waiting, the transfer ends with `done` and error class BUSY (code 1), and no command is issued.
- R2: On status 0x08 or 0x10, a SEND (code 3) is issued with the address byte. The address byte holds the 7-bit address in bits 7..1 and the read flag in bit 0.
- R3: On status 0x18 or 0x28, while bytes of the current write message remain, a SEND carries the next `wr_data` byte and `wr_take` pulses in the same cycle.
- R4: A write message of length zero sends only its address byte. It then counts as complete and the sequencer moves on.
- R5: On status 0x40, a RECV (code 4) is issued with `eng_ack` set only when the read length is greater than one. After each byte taken on status 0x50, the following RECV has `eng_ack` set only while at least two further bytes are still to come.
- R6: On status 0x58, the byte is accepted only when it is the last byte of the message. Otherwise a STOP (code 2) is issued, no byte is output, and the transfer ends with error class ABORT (code 3).
- R7: When a message finishes (write bytes exhausted, or last read byte taken), the sequencer issues a START if more messages follow. After the last message it issues a STOP and ends with error class NONE (code 0) and `done_count` equal to `msg_num`.
- R8: Status 0x20 or 0x48 (address not acknowledged) issues a STOP and ends the transfer with error class NODEV (code 2).
- R9: Status 0x30 (data not acknowledged) issues a STOP and ends the transfer with error class ABORT (code 3). `done_count` gives the number of messages that finished before it.
- R10: Status 0x38 (arbitration lost) issues a START and ends the transfer with error class ARB (code 4).
- R11: Status 0x70, 0x90 or 0x00 issues a RESET (code 5) and ends the transfer with error class BUSERR (code 5).
- R12: Any other status pulses `bad_status`, issues no command and does not end the transfer. The next event is then decoded as usual.
- R13: Every accepted read byte appears on `rd_data` with a one-cycle `rd_valid` pulse, in the cycle after the event that carried it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start a transfer (ignored while busy) |
| msg_num | input | MSG_W | Number of messages in the list |
| desc_idx | output | MSG_W | Index of the current message |
| desc_addr | input | 7 | 7-bit target address of the indexed message |
| desc_rd | input | 1 | 1 = read message |
| desc_len | input | LEN_W | Byte count of the indexed message |
| wr_data | input | 8 | Next byte of the write stream |
| wr_take | output | 1 | Write byte consumed this cycle |
| rd_valid | output | 1 | Read byte valid |
| rd_data | output | 8 | Read byte |
| eng_status | input | 8 | Engine status code |
| eng_si | input | 1 | Engine event pulse |
| eng_rdata | input | 8 | Byte received by the engine |
| eng_cmd_valid | output | 1 | Command strobe |
| eng_cmd | output | 3 | 1 START, 2 STOP, 3 SEND, 4 RECV, 5 RESET |
| eng_wdata | output | 8 | Byte for a SEND |
| eng_ack | output | 1 | ACK the next received byte |
| bad_status | output | 1 | Unknown status seen |
| done | output | 1 | Transfer finished |
| done_count | output | MSG_W | Messages completed |
| done_err | output | 3 | 0 NONE, 1 BUSY, 2 NODEV, 3 ABORT, 4 ARB, 5 BUSERR |

## Verification
The bench aims at the ACK plan near the end of a read. A design that is off by one in the remaining-byte test would ACK the final byte, or NACK one byte too early and then see 0x58 on a byte that is not the last. It also checks a one-byte read, an early 0x58 that has to abort without emitting the byte, and a zero-length write that must move on without consuming stream data. Each error status is checked for both the closing command and the reported count, since a slip there sends the wrong bus action or loses track of messages already finished. The bench also feeds an unknown code followed by a valid one, to show that the sequencer neither stalls nor ends the transfer early.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_START = 3'd1,
    CMD_STOP  = 3'd2,
    CMD_SEND  = 3'd3,
    CMD_RECV  = 3'd4,
    CMD_RESET = 3'd5
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_BUSY  = 3'd1,
    ERR_NODEV = 3'd2,
    ERR_ABORT = 3'd3,
    ERR_ARB   = 3'd4,
    ERR_BUS   = 3'd5
  } err_e;

  localparam logic [7:0] ST_IDLE    = 8'hF8;
  localparam logic [7:0] ST_START   = 8'h08;
  localparam logic [7:0] ST_RSTART  = 8'h10;
  localparam logic [7:0] ST_AW_ACK  = 8'h18;
  localparam logic [7:0] ST_AW_NACK = 8'h20;
  localparam logic [7:0] ST_DW_ACK  = 8'h28;
  localparam logic [7:0] ST_DW_NACK = 8'h30;
  localparam logic [7:0] ST_ARB     = 8'h38;
  localparam logic [7:0] ST_AR_ACK  = 8'h40;
  localparam logic [7:0] ST_AR_NACK = 8'h48;
  localparam logic [7:0] ST_DR_ACK  = 8'h50;
  localparam logic [7:0] ST_DR_NACK = 8'h58;
  localparam logic [7:0] ST_SDA_LOW = 8'h70;
  localparam logic [7:0] ST_SCL_LOW = 8'h90;
  localparam logic [7:0] ST_ILLEGAL = 8'h00;

  typedef struct packed {
    logic issue;
    cmd_e cmd;
    logic ack;
    logic send_addr;
    logic send_wr;
    logic push;
    logic nb_inc;
    logic adv;
    logic fin;
    err_e err;
    logic unk;
  } act_t;
endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int TMO = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(TMO + 1);
  localparam logic [TW-1:0] LAST = TW'(TMO - 1);

  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)             cnt_d = '0;
    else if (cnt_q != LAST) cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/seq_step_decode.sv
module seq_step_decode
  import i2cseq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [7:0]       status,
  input  logic [LEN_W-1:0] nb,
  input  logic [LEN_W-1:0] len,
  input  logic             last,
  output act_t             act
);
  logic [LEN_W:0] nb1, nb2, len_w;
  logic           more;

  assign nb1   = {1'b0, nb} + (LEN_W+1)'(1);
  assign nb2   = {1'b0, nb} + (LEN_W+1)'(2);
  assign len_w = {1'b0, len};
  assign more  = nb < len;

  always_comb begin
    act = '0;
    unique case (status)
      ST_IDLE: begin act.issue = 1'b1; act.cmd = CMD_START; end
      ST_START, ST_RSTART: begin
        act.issue = 1'b1; act.cmd = CMD_SEND; act.send_addr = 1'b1;
      end
      ST_AW_ACK, ST_DW_ACK: begin
        if (more) begin
          act.issue = 1'b1; act.cmd = CMD_SEND;
          act.send_wr = 1'b1; act.nb_inc = 1'b1;
        end else act.adv = 1'b1;
      end
      ST_AR_ACK: begin
        act.issue = 1'b1; act.cmd = CMD_RECV; act.ack = (len > LEN_W'(1));
      end
      ST_DR_ACK: begin
        if (more) begin
          act.push = 1'b1; act.nb_inc = 1'b1;
          act.issue = 1'b1; act.cmd = CMD_RECV; act.ack = (nb2 < len_w);
        end else act.adv = 1'b1;
      end
      ST_DR_NACK: begin
        if (nb1 == len_w) begin act.push = 1'b1; act.adv = 1'b1; end
        else begin
          act.issue = 1'b1; act.cmd = CMD_STOP; act.fin = 1'b1; act.err = ERR_ABORT;
        end
      end
      ST_AW_NACK, ST_AR_NACK: begin
        act.issue = 1'b1; act.cmd = CMD_STOP; act.fin = 1'b1; act.err = ERR_NODEV;
      end
      ST_DW_NACK: begin
        act.issue = 1'b1; act.cmd = CMD_STOP; act.fin = 1'b1; act.err = ERR_ABORT;
      end
      ST_ARB: begin
        act.issue = 1'b1; act.cmd = CMD_START; act.fin = 1'b1; act.err = ERR_ARB;
      end
      ST_SDA_LOW, ST_SCL_LOW, ST_ILLEGAL: begin
        act.issue = 1'b1; act.cmd = CMD_RESET; act.fin = 1'b1; act.err = ERR_BUS;
      end
      default: act.unk = 1'b1;
    endcase
    if (act.adv) begin
      act.issue = 1'b1;
      if (last) begin act.cmd = CMD_STOP; act.fin = 1'b1; act.err = ERR_NONE; end
      else        act.cmd = CMD_START;
    end
  end
endmodule

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer
  import i2cseq_pkg::*;
#(
  parameter int MSG_W = 4,
  parameter int LEN_W = 8,
  parameter int TMO   = 100000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [MSG_W-1:0] msg_num,
  output logic [MSG_W-1:0] desc_idx,
  input  logic [6:0]       desc_addr,
  input  logic             desc_rd,
  input  logic [LEN_W-1:0] desc_len,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  input  logic [7:0]       eng_status,
  input  logic             eng_si,
  input  logic [7:0]       eng_rdata,
  output logic             eng_cmd_valid,
  output logic [2:0]       eng_cmd,
  output logic [7:0]       eng_wdata,
  output logic             eng_ack,
  output logic             bad_status,
  output logic             done,
  output logic [MSG_W-1:0] done_count,
  output logic [2:0]       done_err
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_e;
  localparam logic [MSG_W-1:0] M_ONE = MSG_W'(1);

  st_e              st_q, st_d;
  logic [MSG_W-1:0] cur_q, cur_d, dc_q, dc_d;
  logic [LEN_W-1:0] nb_q, nb_d;
  cmd_e             cmd_q, cmd_d;
  err_e             de_q, de_d;
  logic [7:0]       wd_q, wd_d, rdd_q, rdd_d;
  logic             cv_q, cv_d, ack_q, ack_d, wt_q, wt_d, rv_q, rv_d;
  logic             bad_q, bad_d, dn_q, dn_d;
  logic             last, expired, tmr_run;
  act_t             act;

  assign last    = ({1'b0, cur_q} + (MSG_W+1)'(1)) == {1'b0, msg_num};
  assign tmr_run = (st_q == S_WAIT) && (eng_status != ST_IDLE);

  seq_wait_timer #(.TMO(TMO)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(tmr_run), .expired(expired)
  );

  seq_step_decode #(.LEN_W(LEN_W)) u_dec (
    .status(eng_status), .nb(nb_q), .len(desc_len), .last(last), .act(act)
  );

  always_comb begin
    st_d = st_q;   cur_d = cur_q; nb_d = nb_q;  cmd_d = cmd_q; wd_d = wd_q;
    ack_d = ack_q; rdd_d = rdd_q; dc_d = dc_q;  de_d = de_q;
    cv_d = 1'b0;   wt_d = 1'b0;   rv_d = 1'b0;  bad_d = 1'b0;  dn_d = 1'b0;
    unique case (st_q)
      S_IDLE: if (go) begin st_d = S_WAIT; cur_d = '0; nb_d = '0; end
      S_WAIT: begin
        if (eng_status == ST_IDLE) begin
          cv_d = 1'b1; cmd_d = CMD_START; ack_d = 1'b0; st_d = S_RUN;
        end else if (expired) begin
          dn_d = 1'b1; dc_d = '0; de_d = ERR_BUSY; st_d = S_IDLE;
        end
      end
      default: if (eng_si) begin
        if (act.issue)     begin cv_d = 1'b1; cmd_d = act.cmd; ack_d = act.ack; end
        if (act.send_addr) wd_d = {desc_addr, desc_rd};
        if (act.send_wr)   begin wd_d = wr_data; wt_d = 1'b1; end
        if (act.push)      begin rv_d = 1'b1; rdd_d = eng_rdata; end
        if (act.nb_inc)    nb_d = nb_q + LEN_W'(1);
        if (act.adv)       begin cur_d = cur_q + M_ONE; nb_d = '0; end
        bad_d = act.unk;
        if (act.fin) begin
          st_d = S_IDLE; dn_d = 1'b1; de_d = act.err;
          dc_d = act.adv ? cur_q + M_ONE : cur_q;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; cur_q <= '0; nb_q <= '0; cmd_q <= CMD_NONE; wd_q <= '0;
      ack_q <= 1'b0; rdd_q <= '0; dc_q <= '0; de_q <= ERR_NONE;
      cv_q <= 1'b0; wt_q <= 1'b0; rv_q <= 1'b0; bad_q <= 1'b0; dn_q <= 1'b0;
    end else begin
      st_q <= st_d; cur_q <= cur_d; nb_q <= nb_d; cmd_q <= cmd_d; wd_q <= wd_d;
      ack_q <= ack_d; rdd_q <= rdd_d; dc_q <= dc_d; de_q <= de_d;
      cv_q <= cv_d; wt_q <= wt_d; rv_q <= rv_d; bad_q <= bad_d; dn_q <= dn_d;
    end
  end

  assign desc_idx      = cur_q;
  assign wr_take       = wt_q;
  assign rd_valid      = rv_q;
  assign rd_data       = rdd_q;
  assign eng_cmd_valid = cv_q;
  assign eng_cmd       = cmd_q;
  assign eng_wdata     = wd_q;
  assign eng_ack       = ack_q;
  assign bad_status    = bad_q;
  assign done          = dn_q;
  assign done_count    = dc_q;
  assign done_err      = de_q;

  p_busy_no_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err == ERR_BUSY) |-> !eng_cmd_valid);
  p_take_on_send_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (eng_cmd_valid && eng_cmd == CMD_SEND));
  p_ok_ends_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err == ERR_NONE) |-> (eng_cmd_valid && eng_cmd == CMD_STOP && done_count == msg_num));
  p_nodev_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err == ERR_NODEV) |-> (eng_cmd_valid && eng_cmd == CMD_STOP));
  p_abort_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err == ERR_ABORT) |-> (eng_cmd_valid && eng_cmd == CMD_STOP && !rd_valid));
  p_arb_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err == ERR_ARB) |-> (eng_cmd_valid && eng_cmd == CMD_START));
  p_bus_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err == ERR_BUS) |-> (eng_cmd_valid && eng_cmd == CMD_RESET));
  p_unknown_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bad_status |-> (!eng_cmd_valid && !done));
  p_push_after_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(eng_si) && ($past(eng_status) == ST_DR_ACK || $past(eng_status) == ST_DR_NACK)));
endmodule

// File: tb/tb_i2c_msg_sequencer.sv
module tb_i2c_msg_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 20;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, eng_si = 1'b0;
  logic [3:0] msg_num = '0, desc_idx, done_count;
  logic [6:0] desc_addr;
  logic desc_rd;
  logic [7:0] desc_len, wr_data, rd_data, eng_status = 8'hF8, eng_rdata = '0, eng_wdata;
  logic wr_take, rd_valid, eng_cmd_valid, eng_ack, bad_status, done;
  logic [2:0] eng_cmd, done_err;

  logic [6:0] d_addr [16];
  logic       d_rd   [16];
  logic [7:0] d_len  [16];
  logic [7:0] wbuf   [16];
  int wptr = 0, nchk = 0, nerr = 0;
  logic s_cv, s_ack, s_rv, s_done, s_bad, s_wt;
  logic [2:0] s_cmd;
  logic [7:0] s_wd, s_rdd;

  assign desc_addr = d_addr[desc_idx];
  assign desc_rd   = d_rd[desc_idx];
  assign desc_len  = d_len[desc_idx];
  assign wr_data   = wbuf[wptr[3:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_msg_sequencer #(.MSG_W(4), .LEN_W(8), .TMO(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .go(go), .msg_num(msg_num), .desc_idx(desc_idx),
    .desc_addr(desc_addr), .desc_rd(desc_rd), .desc_len(desc_len), .wr_data(wr_data),
    .wr_take(wr_take), .rd_valid(rd_valid), .rd_data(rd_data), .eng_status(eng_status),
    .eng_si(eng_si), .eng_rdata(eng_rdata), .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd),
    .eng_wdata(eng_wdata), .eng_ack(eng_ack), .bad_status(bad_status), .done(done),
    .done_count(done_count), .done_err(done_err));

  // {status, rdata, cmd, data, ack, rd_valid}
  localparam logic [28:0] VEC [11] = '{
    {8'h08, 8'h00, 3'd3, 8'hA0, 1'b0, 1'b0},
    {8'h18, 8'h00, 3'd3, 8'hA1, 1'b0, 1'b0},
    {8'h28, 8'h00, 3'd3, 8'hB2, 1'b0, 1'b0},
    {8'h28, 8'h00, 3'd1, 8'h00, 1'b0, 1'b0},
    {8'h10, 8'h00, 3'd3, 8'hA3, 1'b0, 1'b0},
    {8'h40, 8'h00, 3'd4, 8'h00, 1'b1, 1'b0},
    {8'h50, 8'h11, 3'd4, 8'h00, 1'b1, 1'b1},
    {8'h50, 8'h22, 3'd4, 8'h00, 1'b0, 1'b1},
    {8'h58, 8'h33, 3'd1, 8'h00, 1'b0, 1'b1},
    {8'h10, 8'h00, 3'd3, 8'h44, 1'b0, 1'b0},
    {8'h18, 8'h00, 3'd2, 8'h00, 1'b0, 1'b0}
  };

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sample();
    s_cv = eng_cmd_valid; s_cmd = eng_cmd; s_wd = eng_wdata; s_ack = eng_ack;
    s_rv = rd_valid; s_rdd = rd_data; s_done = done; s_bad = bad_status; s_wt = wr_take;
    if (wr_take) wptr++;
  endtask

  task automatic step(input logic [7:0] s, input logic [7:0] rd);
    @(negedge clk); eng_status = s; eng_rdata = rd; eng_si = 1'b1;
    @(negedge clk); eng_si = 1'b0;
    sample();
  endtask

  task automatic launch(input logic [3:0] n);
    @(negedge clk); msg_num = n; eng_status = 8'hF8; go = 1'b1; wptr = 0;
    @(negedge clk); go = 1'b0;
    @(negedge clk); sample();
    chk(s_cv && s_cmd == 3'd1, "R1 start on idle", s_cmd, 1);
  endtask

  task automatic expect_cmd(input string req, input logic [2:0] c);
    chk(s_cv && s_cmd == c, req, {s_cv, s_cmd}, {1'b1, c});
  endtask

  task automatic expect_end(input string req, input logic [2:0] e, input logic [3:0] n);
    chk(s_done && done_err == e && done_count == n, req,
        {s_done, done_err, done_count}, {1'b1, e, n});
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      d_addr[i] = '0; d_rd[i] = 1'b0; d_len[i] = '0; wbuf[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk(!eng_cmd_valid && !done && !rd_valid && !wr_take && !bad_status,
        "R1 reset quiet", {eng_cmd_valid, done, rd_valid, wr_take}, 0);
    chk(done_err == 3'd0 && done_count == 4'd0, "R7 reset result", done_err, 0);
    rst_n = 1'b1;

    // Table: write 2 to 0x50, read 3 from 0x51, zero-length write to 0x22
    d_addr[0] = 7'h50; d_rd[0] = 1'b0; d_len[0] = 8'd2;
    d_addr[1] = 7'h51; d_rd[1] = 1'b1; d_len[1] = 8'd3;
    d_addr[2] = 7'h22; d_rd[2] = 1'b0; d_len[2] = 8'd0;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hEE;
    launch(4'd3);
    for (int i = 0; i < 11; i++) begin
      logic [28:0] v;
      v = VEC[i];
      step(v[28:21], v[20:13]);
      chk(s_cv && s_cmd == v[12:10], $sformatf("R2/R3/R7 table step %0d cmd", i), s_cmd, v[12:10]);
      if (v[12:10] == 3'd3)
        chk(s_wd == v[9:2], $sformatf("R2/R3 table step %0d byte", i), s_wd, v[9:2]);
      if (v[12:10] == 3'd4)
        chk(s_ack == v[1], $sformatf("R5 table step %0d ack", i), s_ack, v[1]);
      chk(s_rv == v[0] && (!v[0] || s_rdd == v[20:13]),
          $sformatf("R13 table step %0d read out", i), {s_rv, s_rdd}, {v[0], v[20:13]});
    end
    expect_end("R7 R4 three messages done", 3'd0, 4'd3);
    chk(wptr == 2, "R4 zero-length write takes no stream byte", wptr, 2);

    // Busy timeout
    @(negedge clk); eng_status = 8'h70; go = 1'b1;
    @(negedge clk); go = 1'b0;
    begin
      int n; logic seen;
      n = 0; seen = 1'b0;
      while (!done && n < 100) begin
        @(negedge clk); n++;
        if (eng_cmd_valid) seen = 1'b1;
      end
      chk(n == TMO, "R1 timeout cycle count", n, TMO);
      chk(done_err == 3'd1 && !seen, "R1 busy error no command", {seen, done_err}, 1);
    end

    // Address NACK on read
    d_addr[0] = 7'h30; d_rd[0] = 1'b1; d_len[0] = 8'd2;
    launch(4'd1);
    step(8'h08, 0); chk(s_wd == 8'h61, "R2 read address byte", s_wd, 8'h61);
    step(8'h48, 0); expect_cmd("R8 stop on address nack", 3'd2);
    expect_end("R8 nodev", 3'd2, 4'd0);

    // Data NACK in second message
    d_addr[0] = 7'h11; d_rd[0] = 1'b0; d_len[0] = 8'd1;
    d_addr[1] = 7'h12; d_rd[1] = 1'b0; d_len[1] = 8'd1;
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    launch(4'd2);
    step(8'h08, 0); step(8'h18, 0);
    chk(s_wt && s_wd == 8'h5A, "R3 first write byte", s_wd, 8'h5A);
    step(8'h28, 0); expect_cmd("R7 repeated start", 3'd1);
    step(8'h10, 0); step(8'h18, 0);
    chk(s_wd == 8'hC3, "R3 second message byte", s_wd, 8'hC3);
    step(8'h30, 0); expect_cmd("R9 stop on data nack", 3'd2);
    expect_end("R9 abort with one done", 3'd3, 4'd1);

    // Early NACKed read byte
    d_addr[0] = 7'h40; d_rd[0] = 1'b1; d_len[0] = 8'd3;
    launch(4'd1);
    step(8'h08, 0);
    step(8'h40, 0); chk(s_ack == 1'b1, "R5 ack when length 3", s_ack, 1);
    step(8'h58, 8'h55); expect_cmd("R6 stop on early nack", 3'd2);
    chk(!s_rv, "R6 early byte not output", s_rv, 0);
    expect_end("R6 abort", 3'd3, 4'd0);

    // One-byte read
    d_len[0] = 8'd1;
    launch(4'd1);
    step(8'h08, 0);
    step(8'h40, 0); chk(s_cmd == 3'd4 && s_ack == 1'b0, "R5 nack for single byte", s_ack, 0);
    step(8'h58, 8'h77); chk(s_rv && s_rdd == 8'h77, "R6 R13 last byte accepted", s_rdd, 8'h77);
    expect_cmd("R7 stop after last", 3'd2);
    expect_end("R7 single read ok", 3'd0, 4'd1);

    // Arbitration loss
    launch(4'd1);
    step(8'h38, 0); expect_cmd("R10 start re-request", 3'd1);
    expect_end("R10 arb error", 3'd4, 4'd0);

    // Bus errors
    launch(4'd1);
    step(8'h08, 0); step(8'h90, 0); expect_cmd("R11 reset on 0x90", 3'd5);
    expect_end("R11 buserr 0x90", 3'd5, 4'd0);
    launch(4'd1);
    step(8'h00, 0); expect_cmd("R11 reset on 0x00", 3'd5);
    expect_end("R11 buserr 0x00", 3'd5, 4'd0);

    // Unknown status, then zero-length write finishes
    d_addr[0] = 7'h12; d_rd[0] = 1'b0; d_len[0] = 8'd0;
    launch(4'd1);
    step(8'h99, 0);
    chk(s_bad && !s_cv && !s_done, "R12 unknown flagged no command", {s_bad, s_cv, s_done}, 3'b100);
    step(8'h08, 0); chk(s_cv && s_wd == 8'h24, "R12 continues after unknown", s_wd, 8'h24);
    step(8'h18, 0); expect_cmd("R4 zero-length then stop", 3'd2);
    expect_end("R4 zero-length done", 3'd0, 4'd1);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule